// File: doc/BRIEF.md
# Jack Insertion Detect Debouncer

This block turns the raw tip-sense level of a headphone socket into clean plugged and unplugged status bits. The sense input arrives asynchronously. It is brought into the clock domain and optionally inverted. It is then filtered by a counter that runs on an external millisecond tick. The hold time for a low-to-high change and the hold time for a high-to-low change are chosen separately. Each can be zero, a quarter second, half a second or a full second.

Every accepted change to plugged sets a sticky plug interrupt flag. Every accepted change to unplugged sets a sticky unplug interrupt flag. Software clears each flag with a one-cycle write-one strobe. A two-bit mode field switches detection on. Every other value of that field shuts reporting off and wipes both flags.

The tick period and the length of one interval step are parameters, so the same logic serves any tick source. With `TICKS_PER_STEP = 250` and a 1 ms tick, the four settings give the nominal times.

Top module: `jack_detect_debounce`

## Requirements
- R1: Detection runs only while `det_mode` is 2'b11. The values 2'b00, 2'b01 and 2'b10 all mean disabled.
- R2: While disabled, `plug_status` and `unplug_status` are both 0. Both interrupt flags read 0 from the cycle after the clock edge that samples the disabled mode.
- R3: A selector value of 00, 01, 10 or 11 sets the hold time to 0, 1×, 2× or 4× `TICKS_PER_STEP` millisecond ticks, respectively.
- R4: A change toward plugged is accepted once the new level has stayed put through the number of ticks set by `rise_sel`. A change toward unplugged uses `fall_sel` in the same way.
- R5: If the level returns to the accepted state before the hold time is up, the partial count is discarded. A later change must count its full hold time again.
- R6: With a zero hold time, a change on `sense_async` shows on the status outputs three clock edges later: two synchronizer stages plus the accepting edge.
- R7: When `det_invert` is 1, the synchronized sense level is inverted before filtering, so the meaning of plugged is reversed. A change of `det_invert` acts like a change of the sense level.
- R8: While enabled, `plug_status` is 1 exactly when the accepted state is plugged, and `unplug_status` is its complement. After reset both read 0.
- R9: An accepted change to plugged sets `plug_irq`, and an accepted change to unplugged sets `unplug_irq`. Each flag stays 1 until a cycle with its clear strobe high.
- R10: If a flag's clear strobe and a new event for that flag fall in the same cycle, the flag ends up set.
- R11: When detection is switched on, the accepted state starts as unplugged. A jack that is already in therefore produces a plug event after the rise hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| sense_async | input | 1 | Raw tip-sense level, asynchronous |
| det_mode | input | 2 | Detection mode; 2'b11 enables |
| det_invert | input | 1 | Invert the sense polarity |
| rise_sel | input | 2 | Hold time toward plugged |
| fall_sel | input | 2 | Hold time toward unplugged |
| plug_irq_clr | input | 1 | Write-one clear of the plug flag |
| unplug_irq_clr | input | 1 | Write-one clear of the unplug flag |
| plug_status | output | 1 | Debounced plugged condition |
| unplug_status | output | 1 | Debounced unplugged condition |
| plug_irq | output | 1 | Sticky plug interrupt |
| unplug_irq | output | 1 | Sticky unplug interrupt |

## Verification
The clear strobe of a sticky flag and an accepted event for that same flag can land on the same clock edge. The bench provokes this by leaving the plug flag set and going through an unplug. It then re-inserts the jack with a zero hold time and raises the plug clear exactly on the third edge after the sense change, the edge where the new level is accepted. The flag must read 1 afterwards, and a lone clear strobe on a later cycle must then bring it to 0.

// File: rtl/jdd_pkg.sv
package jdd_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RSV1 = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_ON   = 2'b11
  } det_mode_e;

  // hold time in ticks for a selector: 0, 1, 2 or 4 steps
  function automatic int unsigned hold_ticks(input logic [1:0] sel,
                                             input int unsigned step);
    case (sel)
      2'b00:   return 0;
      2'b01:   return step;
      2'b10:   return 2 * step;
      default: return 4 * step;
    endcase
  endfunction

  function automatic logic mode_enabled(input logic [1:0] mode);
    return mode == MODE_ON;
  endfunction

endpackage

// File: rtl/jdd_sync.sv
module jdd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/jdd_filter.sv
module jdd_filter #(
  parameter int unsigned TICKS_PER_STEP = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       level,
  input  logic       ms_tick,
  input  logic [1:0] rise_sel,
  input  logic [1:0] fall_sel,
  output logic       accepted,
  output logic       rise_evt,
  output logic       fall_evt
);
  import jdd_pkg::*;

  localparam int unsigned MAX_TICKS = 4 * TICKS_PER_STEP;
  localparam int CW = $clog2(MAX_TICKS + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          differs;
  logic          take;

  always_comb begin
    limit   = level ? CW'(hold_ticks(rise_sel, TICKS_PER_STEP))
                    : CW'(hold_ticks(fall_sel, TICKS_PER_STEP));
    differs = enable && (level != accepted);
    take    = differs && ((limit == '0) || (ms_tick && (cnt + 1'b1 >= limit)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accepted <= 1'b0;
      cnt      <= '0;
    end else if (!enable) begin
      accepted <= 1'b0;
      cnt      <= '0;
    end else if (!differs) begin
      cnt <= '0;
    end else if (take) begin
      accepted <= level;
      cnt      <= '0;
    end else if (ms_tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rise_evt = take && level;
  assign fall_evt = take && !level;
endmodule

// File: rtl/jdd_flags.sv
module jdd_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[i] <= 1'b0;
      else if (!enable)  flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/jack_detect_debounce.sv
module jack_detect_debounce #(
  parameter int unsigned TICKS_PER_STEP = 250,
  parameter int          SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       sense_async,
  input  logic [1:0] det_mode,
  input  logic       det_invert,
  input  logic [1:0] rise_sel,
  input  logic [1:0] fall_sel,
  input  logic       plug_irq_clr,
  input  logic       unplug_irq_clr,
  output logic       plug_status,
  output logic       unplug_status,
  output logic       plug_irq,
  output logic       unplug_irq
);
  import jdd_pkg::*;

  logic       sense_sync;
  logic       level;
  logic       enabled;
  logic       accepted;
  logic       rise_evt;
  logic       fall_evt;
  logic [1:0] flags;

  assign enabled = mode_enabled(det_mode);

  jdd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sense_async), .d_sync(sense_sync)
  );

  assign level = sense_sync ^ det_invert;

  jdd_filter #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_filter (
    .clk(clk), .rst_n(rst_n), .enable(enabled), .level(level),
    .ms_tick(ms_tick), .rise_sel(rise_sel), .fall_sel(fall_sel),
    .accepted(accepted), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  jdd_flags #(.N(2)) u_flags (
    .clk(clk), .rst_n(rst_n), .enable(enabled),
    .set_i({fall_evt, rise_evt}),
    .clr_i({unplug_irq_clr, plug_irq_clr}),
    .flag_o(flags)
  );

  assign plug_status   = enabled && accepted;
  assign unplug_status = enabled && !accepted;
  assign plug_irq      = flags[0];
  assign unplug_irq    = flags[1];
endmodule

// File: rtl/jdd_checker.sv
module jdd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic [1:0] det_mode,
  input logic [1:0] rise_sel,
  input logic       plug_irq_clr,
  input logic       plug_status,
  input logic       unplug_status,
  input logic       plug_irq,
  input logic       unplug_irq,
  input logic       rise_evt
);
  AST_OFF_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (det_mode != 2'b11) |-> (!plug_status && !unplug_status)); // R2
  AST_OFF_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (det_mode != 2'b11) |=> (!plug_irq && !unplug_irq)); // R2
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (det_mode == 2'b11) |-> (plug_status != unplug_status)); // R8
  AST_PLUG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (plug_irq && !plug_irq_clr && det_mode == 2'b11 && !rise_evt) |=> plug_irq); // R9
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && plug_irq_clr && det_mode == 2'b11) |=> plug_irq); // R10
  AST_TIMED_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (det_mode == 2'b11 && rise_sel != 2'b00 && rise_evt) |-> ms_tick); // R4
endmodule

bind jack_detect_debounce jdd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .det_mode(det_mode),
  .rise_sel(rise_sel), .plug_irq_clr(plug_irq_clr),
  .plug_status(plug_status), .unplug_status(unplug_status),
  .plug_irq(plug_irq), .unplug_irq(unplug_irq), .rise_evt(rise_evt)
);

// File: tb/sim_jack_detect_debounce.sv
`timescale 1ns/1ps
module sim_jack_detect_debounce;
  localparam int unsigned STEP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       sense_async = 1'b0;
  logic [1:0] det_mode = 2'b00;
  logic       det_invert = 1'b0;
  logic [1:0] rise_sel = 2'b00;
  logic [1:0] fall_sel = 2'b10;
  logic       plug_irq_clr = 1'b0;
  logic       unplug_irq_clr = 1'b0;
  logic       plug_status, unplug_status, plug_irq, unplug_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  jack_detect_debounce #(.TICKS_PER_STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sense_async(sense_async),
    .det_mode(det_mode), .det_invert(det_invert), .rise_sel(rise_sel),
    .fall_sel(fall_sel), .plug_irq_clr(plug_irq_clr),
    .unplug_irq_clr(unplug_irq_clr), .plug_status(plug_status),
    .unplug_status(unplug_status), .plug_irq(plug_irq), .unplug_irq(unplug_irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      step(1);
      ms_tick = 1'b0;
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  function automatic int hold(input logic [1:0] sel);
    return (sel == 2'b00) ? 0 : (sel == 2'b01) ? STEP : (sel == 2'b10) ? 2*STEP : 4*STEP;
  endfunction

  task automatic t_reset();
    chk(plug_status, 1'b0, "R8 reset plug_status");
    chk(unplug_status, 1'b0, "R8 reset unplug_status");
    chk(plug_irq, 1'b0, "R8 reset plug_irq");
    chk(unplug_irq, 1'b0, "R8 reset unplug_irq");
  endtask

  task automatic t_enable_zero_rise();
    det_mode = 2'b11; rise_sel = 2'b00;
    step(1);
    chk(unplug_status, 1'b1, "R1 enabled unplugged");
    sense_async = 1'b1;
    step(2);
    chk(plug_status, 1'b0, "R6 not yet after two edges");
    step(1);
    chk(plug_status, 1'b1, "R6 plugged on third edge");
    chk(plug_irq, 1'b1, "R9 plug_irq set");
    plug_irq_clr = 1'b1; step(1); plug_irq_clr = 1'b0;
    chk(plug_irq, 1'b0, "R9 plug_irq cleared");
    chk(plug_status, 1'b1, "R9 clear leaves status");
  endtask

  task automatic t_fall_timed();
    fall_sel = 2'b10;
    sense_async = 1'b0;
    step(3);
    tick(hold(fall_sel) - 1);
    chk(plug_status, 1'b1, "R3 R4 still plugged one tick short");
    tick(1);
    chk(unplug_status, 1'b1, "R4 unplugged after fall hold");
    chk(unplug_irq, 1'b1, "R9 unplug_irq set");
    step(5);
    chk(unplug_irq, 1'b1, "R9 unplug_irq sticky");
    unplug_irq_clr = 1'b1; step(1); unplug_irq_clr = 1'b0;
    chk(unplug_irq, 1'b0, "R9 unplug_irq cleared");
  endtask

  task automatic t_restart();
    rise_sel = 2'b01;
    sense_async = 1'b1; step(3);
    tick(1);
    sense_async = 1'b0; step(3);
    sense_async = 1'b1; step(3);
    tick(1);
    chk(plug_status, 1'b0, "R5 count restarted");
    tick(hold(rise_sel) - 1);
    chk(plug_status, 1'b1, "R5 R4 plugged after full rise hold");
  endtask

  task automatic t_invert();
    fall_sel = 2'b00; rise_sel = 2'b00;
    det_invert = 1'b1; step(1);
    chk(unplug_status, 1'b1, "R7 invert reads unplugged");
    det_invert = 1'b0; step(1);
    chk(plug_status, 1'b1, "R7 invert off reads plugged");
    plug_irq_clr = 1'b1; unplug_irq_clr = 1'b1; step(1);
    plug_irq_clr = 1'b0; unplug_irq_clr = 1'b0;
  endtask

  task automatic t_reserved_mode();
    sense_async = 1'b0; step(3);
    chk(unplug_irq, 1'b1, "R9 unplug before disable");
    det_mode = 2'b01; step(1);
    chk(plug_status, 1'b0, "R1 mode 01 no plug status");
    chk(unplug_status, 1'b0, "R2 mode 01 no unplug status");
    chk(unplug_irq, 1'b0, "R2 flag wiped");
    det_mode = 2'b10; sense_async = 1'b1; step(4);
    chk(plug_status | plug_irq, 1'b0, "R1 mode 10 ignores insertion");
    det_mode = 2'b00; step(1);
  endtask

  task automatic t_enable_inserted();
    rise_sel = 2'b01;
    det_mode = 2'b11; step(1);
    chk(unplug_status, 1'b1, "R11 starts unplugged");
    tick(hold(rise_sel) - 1);
    chk(plug_status, 1'b0, "R11 not before hold");
    tick(1);
    chk(plug_status, 1'b1, "R11 plug event after rise hold");
    chk(plug_irq, 1'b1, "R11 plug_irq");
  endtask

  task automatic t_collision();
    rise_sel = 2'b00; fall_sel = 2'b00;
    sense_async = 1'b0; step(3);
    chk(plug_irq, 1'b1, "R10 plug flag left set");
    sense_async = 1'b1; step(2);
    plug_irq_clr = 1'b1; step(1); plug_irq_clr = 1'b0;
    chk(plug_status, 1'b1, "R10 replugged");
    chk(plug_irq, 1'b1, "R10 set wins over clear");
    plug_irq_clr = 1'b1; step(1); plug_irq_clr = 1'b0;
    chk(plug_irq, 1'b0, "R9 lone clear");
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_enable_zero_rise();
    t_fall_timed();
    t_restart();
    t_invert();
    t_reserved_mode();
    t_enable_inserted();
    t_collision();
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule